// File: doc/BRIEF.md
# Supply Supervisor Reset Sequencer

This block turns two already-digitized comparator flags into a clean system reset. One flag reports that the main supply is above its trip point. The other reports the same for a secondary rail. While the main supply is low, reset is held active. Once the supply has recovered, reset stays active for a release timeout and only then lets go. Software or straps pick one of four timeout lengths at runtime through a two-bit select. A separate fail flag follows the secondary rail with only synchronizer delay, so the system can treat it either as an early power-loss warning or as an extra reset term.

Both flags pass through two-flop synchronizers. The timeout is counted in ticks from a free-running prescaler, so its resolution is one tick. A power-on input from the analog power detector forces reset active and clears all state. All pins are plain level signals: the block has no data stream and no handshake.

Top module: `supply_reset_seq`

## Requirements
- R1: Within three clock edges of the main flag going low, `rst_o` is 1, and it stays 1 for as long as the main flag stays low.
- R2: After the main flag rises and then stays high, `rst_o` falls at edge E, counted from the first edge after the rise. E satisfies (N-1)*TICK_DIV+4 <= E <= N*TICK_DIV+3, where N is the selected tick count. After `rst_o` falls it stays 0 while the main flag stays high.
- R3: `hold_sel_i` maps 2'b00 to HOLD_T0 ticks, 2'b01 to HOLD_T1, 2'b10 to HOLD_T2 and 2'b11 to HOLD_T3. The defaults are 50, 200, 400 and 800 ticks of 1 ms, that is 0.05 s, 0.2 s, 0.4 s and 0.8 s.
- R4: `rst_n_o` is always the complement of `rst_o`.
- R5: `fail_o` equals the secondary flag as sampled two clock edges earlier, with no timeout. It does this whatever the state of reset.
- R6: While `por_n_i` is low, `rst_o` is 1. After `por_n_i` rises with the main flag already high, release follows the R2 window, counted from the first edge after `por_n_i` rises.
- R7: If the main flag drops during the timeout, the tick count restarts from zero. The R2 window is then counted from the main flag's next rise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| por_n_i | input | 1 | Asynchronous power-on reset from the analog power detector, active low |
| main_ok_i | input | 1 | Main-supply comparator flag, 1 = above trip point (asynchronous) |
| sec_ok_i | input | 1 | Secondary-rail comparator flag, 1 = above trip point (asynchronous) |
| hold_sel_i | input | 2 | Release timeout select |
| rst_o | output | 1 | System reset, active high |
| rst_n_o | output | 1 | System reset, active low |
| fail_o | output | 1 | Secondary rail good, 0 = rail below trip point |

## Verification
The hardest case to reach from the ports is a main-supply dropout that lands part-way through a running timeout. The dropout must be long enough to pass the synchronizer, yet it must end before the count would have released reset. It also has to happen at an arbitrary phase of the free-running prescaler. The stimulus raises the main flag and waits a random number of cycles that is bounded below the earliest possible release. It then pulls the flag low for exactly the synchronizer depth plus one, and raises it again. The release is then measured against the window counted from the second rise. Because the prescaler phase is not visible at the ports, every release check accepts the one-tick window.

// File: rtl/srs_pkg.sv
package srs_pkg;

  typedef enum logic [1:0] {
    HOLD_T0 = 2'b00,
    HOLD_T1 = 2'b01,
    HOLD_T2 = 2'b10,
    HOLD_T3 = 2'b11
  } hold_sel_e;

  // Tick count for a given select code
  function automatic int unsigned hold_ticks(input logic [1:0] sel,
                                             input int unsigned t0,
                                             input int unsigned t1,
                                             input int unsigned t2,
                                             input int unsigned t3);
    case (hold_sel_e'(sel))
      HOLD_T0: hold_ticks = t0;
      HOLD_T1: hold_ticks = t1;
      HOLD_T2: hold_ticks = t2;
      default: hold_ticks = t3;
    endcase
  endfunction

endpackage

// File: rtl/srs_sync.sv
module srs_sync #(
  parameter int unsigned WIDTH = 2
) (
  input  logic             clk_i,
  input  logic             por_n_i,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic meta_q, stab_q;
    always_ff @(posedge clk_i or negedge por_n_i) begin
      if (!por_n_i) begin
        meta_q <= 1'b0;
        stab_q <= 1'b0;
      end else begin
        meta_q <= async_i[g];
        stab_q <= meta_q;
      end
    end
    assign sync_o[g] = stab_q;
  end

endmodule

// File: rtl/srs_tick_gen.sv
module srs_tick_gen #(
  parameter int unsigned TICK_DIV = 50000
) (
  input  logic clk_i,
  input  logic por_n_i,
  output logic tick_o
);

  localparam int unsigned PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(TICK_DIV - 1);

  logic [PW-1:0] pre_q;

  always_ff @(posedge clk_i or negedge por_n_i) begin
    if (!por_n_i)           pre_q <= '0;
    else if (pre_q == LAST) pre_q <= '0;
    else                    pre_q <= pre_q + 1'b1;
  end

  assign tick_o = (pre_q == LAST);

endmodule

// File: rtl/srs_hold_ctr.sv
module srs_hold_ctr
  import srs_pkg::*;
#(
  parameter int unsigned HOLD_T0 = 50,
  parameter int unsigned HOLD_T1 = 200,
  parameter int unsigned HOLD_T2 = 400,
  parameter int unsigned HOLD_T3 = 800
) (
  input  logic       clk_i,
  input  logic       por_n_i,
  input  logic       ok_i,
  input  logic       tick_i,
  input  logic [1:0] sel_i,
  output logic       done_o
);

  localparam int unsigned TMAX01 = (HOLD_T0 > HOLD_T1) ? HOLD_T0 : HOLD_T1;
  localparam int unsigned TMAX23 = (HOLD_T2 > HOLD_T3) ? HOLD_T2 : HOLD_T3;
  localparam int unsigned TMAX   = (TMAX01 > TMAX23) ? TMAX01 : TMAX23;
  localparam int unsigned CW     = $clog2(TMAX + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] limit;

  assign limit  = CW'(hold_ticks(sel_i, HOLD_T0, HOLD_T1, HOLD_T2, HOLD_T3));
  assign done_o = (cnt_q >= limit);

  always_ff @(posedge clk_i or negedge por_n_i) begin
    if (!por_n_i)              cnt_q <= '0;
    else if (!ok_i)            cnt_q <= '0;
    else if (tick_i && !done_o) cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/supply_reset_seq.sv
module supply_reset_seq #(
  parameter int unsigned TICK_DIV = 50000,
  parameter int unsigned HOLD_T0  = 50,
  parameter int unsigned HOLD_T1  = 200,
  parameter int unsigned HOLD_T2  = 400,
  parameter int unsigned HOLD_T3  = 800
) (
  input  logic       clk_i,
  input  logic       por_n_i,
  input  logic       main_ok_i,
  input  logic       sec_ok_i,
  input  logic [1:0] hold_sel_i,
  output logic       rst_o,
  output logic       rst_n_o,
  output logic       fail_o
);

  localparam int unsigned NFLAG = 2;
  localparam int unsigned IDX_MAIN = 0;
  localparam int unsigned IDX_SEC  = 1;

  logic [NFLAG-1:0] flags_s;
  logic             main_ok_s;
  logic             tick;
  logic             hold_done;
  logic             rst_q;

  srs_sync #(.WIDTH(NFLAG)) u_sync (
    .clk_i   (clk_i),
    .por_n_i (por_n_i),
    .async_i ({sec_ok_i, main_ok_i}),
    .sync_o  (flags_s)
  );

  assign main_ok_s = flags_s[IDX_MAIN];

  srs_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk_i   (clk_i),
    .por_n_i (por_n_i),
    .tick_o  (tick)
  );

  srs_hold_ctr #(
    .HOLD_T0(HOLD_T0), .HOLD_T1(HOLD_T1),
    .HOLD_T2(HOLD_T2), .HOLD_T3(HOLD_T3)
  ) u_hold (
    .clk_i   (clk_i),
    .por_n_i (por_n_i),
    .ok_i    (main_ok_s),
    .tick_i  (tick),
    .sel_i   (hold_sel_i),
    .done_o  (hold_done)
  );

  always_ff @(posedge clk_i or negedge por_n_i) begin
    if (!por_n_i) rst_q <= 1'b1;
    else          rst_q <= !(main_ok_s && hold_done);
  end

  assign rst_o   = rst_q;
  assign rst_n_o = ~rst_q;
  assign fail_o  = flags_s[IDX_SEC];

endmodule

// File: rtl/srs_checker.sv
module srs_checker
  import srs_pkg::*;
#(
  parameter int unsigned TICK_DIV = 50000,
  parameter int unsigned HOLD_T0  = 50,
  parameter int unsigned HOLD_T1  = 200,
  parameter int unsigned HOLD_T2  = 400,
  parameter int unsigned HOLD_T3  = 800
) (
  input logic       clk_i,
  input logic       por_n_i,
  input logic       main_ok_s,
  input logic       sec_ok_i,
  input logic [1:0] hold_sel_i,
  input logic       rst_o,
  input logic       fail_o
);

  int unsigned run_q;
  int unsigned since_q;
  int unsigned need;

  assign need = (hold_ticks(hold_sel_i, HOLD_T0, HOLD_T1, HOLD_T2, HOLD_T3) - 1) * TICK_DIV + 1;

  always_ff @(posedge clk_i or negedge por_n_i) begin
    if (!por_n_i) begin
      run_q   <= 0;
      since_q <= 0;
    end else begin
      if (!main_ok_s)               run_q <= 0;
      else if (run_q < 32'h7fff_ffff) run_q <= run_q + 1;
      if (since_q < 3) since_q <= since_q + 1;
    end
  end

  AST_LOW_HOLDS_RESET: assert property (@(posedge clk_i) disable iff (!por_n_i)
    !main_ok_s |=> rst_o); // R1

  AST_NO_EARLY_RELEASE: assert property (@(posedge clk_i) disable iff (!por_n_i)
    $fell(rst_o) |-> (run_q >= need)); // R2

  AST_RELEASE_STAYS: assert property (@(posedge clk_i) disable iff (!por_n_i)
    (!rst_o && main_ok_s) |=> !rst_o); // R2

  AST_FAIL_TRACKS: assert property (@(posedge clk_i) disable iff (!por_n_i)
    (since_q >= 2) |-> (fail_o == $past(sec_ok_i, 2))); // R5

  AST_RISE_RESTARTS: assert property (@(posedge clk_i) disable iff (!por_n_i)
    $rose(main_ok_s) |-> rst_o); // R7

endmodule

bind supply_reset_seq srs_checker #(
  .TICK_DIV(TICK_DIV), .HOLD_T0(HOLD_T0), .HOLD_T1(HOLD_T1),
  .HOLD_T2(HOLD_T2), .HOLD_T3(HOLD_T3)
) u_chk (
  .clk_i      (clk_i),
  .por_n_i    (por_n_i),
  .main_ok_s  (main_ok_s),
  .sec_ok_i   (sec_ok_i),
  .hold_sel_i (hold_sel_i),
  .rst_o      (rst_o),
  .fail_o     (fail_o)
);

// File: tb/sim_supply_reset_seq.sv
module sim_supply_reset_seq;

  localparam int DIV = 3;
  localparam int T0 = 2, T1 = 5, T2 = 9, T3 = 14;

  logic clk = 1'b0, por_n = 1'b0, main_ok = 1'b1, sec_ok = 1'b0;
  logic [1:0] sel = 2'b00;
  logic rst, rst_n, fail;

  int checks = 0, fails = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  supply_reset_seq #(.TICK_DIV(DIV), .HOLD_T0(T0), .HOLD_T1(T1),
                     .HOLD_T2(T2), .HOLD_T3(T3)) u0 (
    .clk_i(clk), .por_n_i(por_n), .main_ok_i(main_ok), .sec_ok_i(sec_ok),
    .hold_sel_i(sel), .rst_o(rst), .rst_n_o(rst_n), .fail_o(fail)
  );

  function automatic int ticks_for(input logic [1:0] s);
    case (s)
      2'b00: return T0;
      2'b01: return T1;
      2'b10: return T2;
      default: return T3;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Counts edges until release; flag change was driven just before
  task automatic count_release(input string req);
    int e = 0;
    int n = ticks_for(sel);
    int lo = (n - 1) * DIV + 4;
    int hi = n * DIV + 3;
    while (rst && e < hi + 10) begin
      @(negedge clk);
      e++;
    end
    chk(e >= lo && e <= hi, req, e, lo);
    chk(rst_n == 1'b1, "R4", rst_n, 1);
  endtask

  task automatic drop_main(input int cyc);
    main_ok = 1'b0;
    repeat (cyc) @(negedge clk);
    chk(rst == 1'b1, "R1", rst, 1);
    chk(rst_n == 1'b0, "R4", rst_n, 0);
  endtask

  task automatic glitch_run(input logic [1:0] s);
    int n, k;
    drop_main(4);
    sel = s;
    n = ticks_for(s);
    main_ok = 1'b1;
    k = $urandom_range(3, (n - 1) * DIV);
    repeat (k) @(negedge clk);
    chk(rst == 1'b1, "R7", rst, 1);
    main_ok = 1'b0;
    repeat (3) @(negedge clk);
    chk(rst == 1'b1, "R7", rst, 1);
    main_ok = 1'b1;
    count_release("R7");
  endtask

  initial begin
    void'($urandom(32'd1234));
    // power-up
    repeat (3) @(negedge clk);
    chk(rst == 1'b1, "R6", rst, 1);
    chk(rst_n == 1'b0, "R4", rst_n, 0);
    chk(fail == 1'b0, "R6", fail, 0);
    por_n = 1'b1;
    count_release("R6");

    // every select, directed
    for (int s = 0; s < 4; s++) begin
      drop_main(5);
      sel = 2'(s);
      main_ok = 1'b1;
      count_release("R3");
      repeat (20) @(negedge clk);
      chk(rst == 1'b0, "R2", rst, 0);
    end

    // long low period keeps reset active
    main_ok = 1'b0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (i >= 3 && rst !== 1'b1) chk(0, "R1", rst, 1);
    end
    chk(rst == 1'b1, "R1", rst, 1);

    // dropout inside timeout, directed and random
    glitch_run(2'b11);
    glitch_run(2'b01);

    // random runs
    for (int i = 0; i < 12; i++) begin
      logic [1:0] s = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 1) == 1) glitch_run(s);
      else begin
        drop_main($urandom_range(3, 8));
        sel = s;
        main_ok = 1'b1;
        count_release("R2");
      end
    end

    // secondary flag follows in both reset states
    for (int i = 0; i < 30; i++) begin
      logic v = 1'($urandom_range(0, 1));
      if (i == 15) main_ok = 1'b0;
      sec_ok = v;
      @(negedge clk);
      @(negedge clk);
      chk(fail == v, "R5", fail, v);
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL R2 watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule